// File: doc/BRIEF.md
# Signed Array Index Range Checker

This block checks that a signed array index lies inside a pair of limits kept in memory, and raises a trap when it does not. A check begins with a one-cycle start strobe. With the strobe come the index, an operand-width select (16 or 32 bits), the byte address of the limit pair, the address of the checking instruction, and a flag saying that the limit operand was encoded as a register rather than as memory.

For a memory operand the block makes two reads over a request/valid port. The first read fetches the lower limit and the second fetches the upper limit. It then compares the index against both limits, inclusive and signed. The block produces exactly one of three one-cycle results: pass, bound trap or invalid-opcode trap. A trap also reports its vector and the address of the checking instruction as the return address. A register-encoded operand gives the invalid-opcode trap at once, with no memory traffic and no comparison.

Top module: `bound_checker`

## Requirements
- R1: After reset, `pass`, `bound_trap`, `ud_trap` and `mem_req` are all low.
- R2: When `start` is sampled with `reg_form` high, `ud_trap` pulses in the next cycle with `trap_vec` = 6. No memory read is issued.
- R3: For a memory operand, the first read is at `base_addr` and the second is at `base_addr` + 2 when `wide` = 0, or at `base_addr` + 4 when `wide` = 1. `mem_wide` equals the sampled `wide`. `mem_req` and `mem_addr` stay steady until `mem_valid`.
- R4: The index passes when lower <= index <= upper under a signed compare. An index equal to either limit passes.
- R5: An index below the lower limit, or above the upper limit, gives a one-cycle `bound_trap` with `trap_vec` = 5.
- R6: When `wide` = 0, bits 31:16 of the index and bits 31:16 of `mem_rdata` are ignored. The index and both limits are sign-extended from bit 15 before the compare.
- R7: Each accepted start produces exactly one result pulse, lasting one cycle. At most one of `pass`, `bound_trap` and `ud_trap` is high in any cycle. A `start` that arrives while a check is in progress is ignored.
- R8: On either trap, `ret_addr` equals the `insn_addr` sampled with the accepted start, so it points at the checking instruction.
- R9: When the lower limit is greater than the upper limit, every index gives `bound_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a check |
| index | input | 32 | Signed index under test |
| wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| base_addr | input | AW | Byte address of the lower limit |
| reg_form | input | 1 | Limit operand encoded as a register (invalid) |
| insn_addr | input | AW | Address of the checking instruction |
| mem_req | output | 1 | Read request, held until `mem_valid` |
| mem_addr | output | AW | Read byte address |
| mem_wide | output | 1 | Read width: 1 = 4 bytes, 0 = 2 bytes |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data; only bits 15:0 are used for 16-bit reads |
| pass | output | 1 | Index within limits (one-cycle pulse) |
| bound_trap | output | 1 | Index out of range (one-cycle pulse) |
| ud_trap | output | 1 | Invalid-opcode trap (one-cycle pulse) |
| trap_vec | output | 8 | Vector of the most recent trap |
| ret_addr | output | AW | Return address of the most recent trap |

## Verification
The assertions assume that `mem_valid` is raised only while `mem_req` is high, for a single cycle per read, and that `mem_rdata` is meaningful in that cycle. The bench memory model counts a latency from the first cycle of a request and answers with one valid cycle. It then waits for the next request. In 16-bit mode it fills the upper half of the read data with a fixed pattern. The bench drives `start` for exactly one cycle. Its only overlapping start is issued on purpose in the middle of a check, to exercise the rule that a start during a check is ignored.

// File: rtl/bound_checker.sv
module bound_checker #(
  parameter int AW = 32,
  parameter logic [7:0] BOUND_VEC = 8'd5,
  parameter logic [7:0] UD_VEC = 8'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   index,
  input  logic          wide,
  input  logic [AW-1:0] base_addr,
  input  logic          reg_form,
  input  logic [AW-1:0] insn_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wide,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  output logic          pass,
  output logic          bound_trap,
  output logic          ud_trap,
  output logic [7:0]    trap_vec,
  output logic [AW-1:0] ret_addr
);

  localparam logic [AW-1:0] STEP16 = AW'(2);
  localparam logic [AW-1:0] STEP32 = AW'(4);

  typedef enum logic [1:0] {IDLE, RD_LO, RD_HI} st_t;

  st_t           st;
  logic [31:0]   idx_q, lo_q, hi_now;
  logic          wide_q;
  logic [AW-1:0] base_q, ip_q;
  logic          in_range;

  function automatic logic [31:0] sext(input logic [31:0] v, input logic w);
    return w ? v : {{16{v[15]}}, v[15:0]};
  endfunction

  assign mem_req  = (st != IDLE);
  assign mem_wide = wide_q;
  assign mem_addr = (st == RD_HI) ? base_q + (wide_q ? STEP32 : STEP16) : base_q;
  assign hi_now   = sext(mem_rdata, wide_q);
  assign in_range = ($signed(idx_q) >= $signed(lo_q)) && ($signed(idx_q) <= $signed(hi_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      idx_q      <= '0;
      lo_q       <= '0;
      wide_q     <= 1'b0;
      base_q     <= '0;
      ip_q       <= '0;
      pass       <= 1'b0;
      bound_trap <= 1'b0;
      ud_trap    <= 1'b0;
      trap_vec   <= '0;
      ret_addr   <= '0;
    end else begin
      pass       <= 1'b0;
      bound_trap <= 1'b0;
      ud_trap    <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (reg_form) begin
            ud_trap  <= 1'b1;
            trap_vec <= UD_VEC;
            ret_addr <= insn_addr;
          end else begin
            idx_q  <= sext(index, wide);
            wide_q <= wide;
            base_q <= base_addr;
            ip_q   <= insn_addr;
            st     <= RD_LO;
          end
        end
        RD_LO: if (mem_valid) begin
          lo_q <= sext(mem_rdata, wide_q);
          st   <= RD_HI;
        end
        RD_HI: if (mem_valid) begin
          st <= IDLE;
          if (in_range) pass <= 1'b1;
          else begin
            bound_trap <= 1'b1;
            trap_vec   <= BOUND_VEC;
            ret_addr   <= ip_q;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r7_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, bound_trap, ud_trap}));
  a_r5_bound_vec: assert property (@(posedge clk) disable iff (!rst_n)
    bound_trap |-> trap_vec == BOUND_VEC);
  a_r2_ud_vec: assert property (@(posedge clk) disable iff (!rst_n)
    ud_trap |-> (trap_vec == UD_VEC && !mem_req));
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_wide)));
  a_r3_hi_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD_HI && $past(st) == RD_LO) |->
      (mem_addr - $past(mem_addr)) == (mem_wide ? STEP32 : STEP16));
  a_r7_result_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || bound_trap) |-> (!mem_req && $past(mem_valid)));

endmodule

// File: tb/tb_bound_checker.sv
module tb_bound_checker;
  localparam int AW = 32;

  logic          clk = 0, rst_n = 0, start = 0, wide = 0, reg_form = 0;
  logic [31:0]   index = 0;
  logic [AW-1:0] base_addr = 0, insn_addr = 0;
  logic          mem_req, mem_wide, pass, bound_trap, ud_trap;
  logic [AW-1:0] mem_addr, ret_addr;
  logic          mem_valid = 0;
  logic [31:0]   mem_rdata = 0;
  logic [7:0]    trap_vec;

  int checks = 0, fails = 0;
  int lat = 1, wcnt = 0, nlog = 0;
  logic [AW-1:0] alog [0:3];
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  bound_checker #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .index(index), .wide(wide),
    .base_addr(base_addr), .reg_form(reg_form), .insn_addr(insn_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .pass(pass),
    .bound_trap(bound_trap), .ud_trap(ud_trap), .trap_vec(trap_vec),
    .ret_addr(ret_addr));

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 0;
      wcnt = 0;
    end else if (mem_req) begin
      wcnt++;
      if (wcnt >= lat) begin
        mem_valid = 1;
        if (nlog < 4) alog[nlog] = mem_addr;
        nlog++;
        if (mem_wide)
          mem_rdata = {mem[mem_addr[7:0]+8'd3], mem[mem_addr[7:0]+8'd2],
                       mem[mem_addr[7:0]+8'd1], mem[mem_addr[7:0]]};
        else
          mem_rdata = {16'hA5A5, mem[mem_addr[7:0]+8'd1], mem[mem_addr[7:0]]};
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [31:0] v, input bit w);
    mem[a] = v[7:0]; mem[a+8'd1] = v[15:8];
    if (w) begin mem[a+8'd2] = v[23:16]; mem[a+8'd3] = v[31:24]; end
  endtask

  // expected outcome: 0 pass, 1 bound trap, 2 invalid opcode
  task automatic run(input logic [31:0] idx, input bit w, input logic [7:0] base,
                     input bit rf, input logic [31:0] ip, input int exp_k, input string rq);
    int got;
    @(negedge clk);
    index = idx; wide = w; base_addr = AW'(base); reg_form = rf; insn_addr = ip;
    nlog = 0; start = 1;
    @(negedge clk);
    start = 0;
    got = -1;
    for (int c = 0; c < 40 && got < 0; c++) begin
      if (pass) got = 0;
      else if (bound_trap) got = 1;
      else if (ud_trap) got = 2;
      else @(negedge clk);
    end
    chk(got == exp_k, rq, got, exp_k);
    if (got == 1) begin
      chk(trap_vec == 8'd5, "R5 vector", trap_vec, 5);
      chk(ret_addr == ip, "R8 return address", ret_addr, ip);
    end
    if (got == 2) begin
      chk(trap_vec == 8'd6, "R2 vector", trap_vec, 6);
      chk(ret_addr == ip, "R8 return address", ret_addr, ip);
      chk(nlog == 0, "R2 no read", nlog, 0);
    end
    if (exp_k != 2) begin
      chk(nlog == 2, "R3 read count", nlog, 2);
      chk(alog[0] == AW'(base), "R3 lower address", alog[0], base);
      chk(alog[1] == AW'(base) + (w ? 4 : 2), "R3 upper address", alog[1], base + (w ? 4 : 2));
    end
    @(negedge clk);
    chk(!(pass || bound_trap || ud_trap), "R7 single-cycle pulse",
        {pass, bound_trap, ud_trap}, 0);
  endtask

  task automatic t_reset;
    chk(!pass && !bound_trap && !ud_trap && !mem_req, "R1 reset outputs",
        {pass, bound_trap, ud_trap, mem_req}, 0);
  endtask

  task automatic t_reg_form;
    run(32'd7, 1, 8'h10, 1, 32'h0000_4000, 2, "R2 register operand");
  endtask

  task automatic t_wide_limits;
    lat = 2;
    put(8'h20, 32'hFFFF_FFF6, 1);  // -10
    put(8'h24, 32'd100, 1);
    run(32'hFFFF_FFF6, 1, 8'h20, 0, 32'h100, 0, "R4 equal lower");
    run(32'd100,       1, 8'h20, 0, 32'h104, 0, "R4 equal upper");
    run(32'd0,         1, 8'h20, 0, 32'h108, 0, "R4 inside");
    run(32'hFFFF_FFF5, 1, 8'h20, 0, 32'h10C, 1, "R5 below lower");
    run(32'd101,       1, 8'h20, 0, 32'h110, 1, "R5 above upper");
    run(32'h8000_0000, 1, 8'h20, 0, 32'h114, 1, "R5 most negative");
  endtask

  task automatic t_narrow;
    lat = 1;
    put(8'h40, 32'h0000_FF00, 0);  // -256
    put(8'h42, 32'h0000_FFFF, 0);  // -1
    run(32'h1234_FF00, 0, 8'h40, 0, 32'h200, 0, "R6 upper index bits ignored");
    run(32'h0000_FFFF, 0, 8'h40, 0, 32'h204, 0, "R6 sign-extended upper limit");
    run(32'h0000_0000, 0, 8'h40, 0, 32'h208, 1, "R6 zero above negative range");
    run(32'h7FFF_FEFF, 0, 8'h40, 0, 32'h20C, 1, "R6 below lower in 16 bit");
  endtask

  task automatic t_inverted;
    lat = 3;
    put(8'h60, 32'd50, 1);
    put(8'h64, 32'd10, 1);
    run(32'd10, 1, 8'h60, 0, 32'h300, 1, "R9 inverted at upper");
    run(32'd30, 1, 8'h60, 0, 32'h304, 1, "R9 inverted between");
    run(32'd50, 1, 8'h60, 0, 32'h308, 1, "R9 inverted at lower");
  endtask

  task automatic t_busy;
    int np, nb, nu;
    lat = 3;
    put(8'h80, 32'd0, 1);
    put(8'h84, 32'd9, 1);
    @(negedge clk);
    index = 32'd5; wide = 1; base_addr = 32'h80; reg_form = 0; insn_addr = 32'h400;
    nlog = 0; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); reg_form = 1; start = 1;
    @(negedge clk); start = 0; reg_form = 0;
    np = 0; nb = 0; nu = 0;
    for (int c = 0; c < 20; c++) begin
      if (pass) np++;
      if (bound_trap) nb++;
      if (ud_trap) nu++;
      @(negedge clk);
    end
    chk(np == 1 && nb == 0 && nu == 0, "R7 start while busy ignored",
        {np[7:0], nb[7:0], nu[7:0]}, 24'h010000);
    chk(nlog == 2, "R7 read count during busy", nlog, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_reg_form;
    t_wide_limits;
    t_narrow;
    t_inverted;
    t_busy;
    t_reg_form;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule